// File: doc/BRIEF.md
# Virtual-Channel Link Flow Controller

This block sits between a packet router and one full-duplex, fixed-rate serial link. The router offers 35-bit flits on eight virtual channels. The controller chooses one flit per cycle and sends it across the link in a link word. At the far end an identical controller files each flit into a 17-entry receive buffer that belongs to its virtual channel.

Flow control is credit based. The sender keeps one counter per channel for the free slots in the far buffer. A packet may start only when that counter covers the whole packet. When the far router drains a flit, one credit becomes owed. The credit travels back inside the next outgoing link word, alongside any data. If there is no data to send, the word goes out as an idle, credit-only word. No separate control wires are used.

Two instances are joined back to back: the `linkTx` of each instance drives the `linkRx` of the other. The link has no backpressure and carries one word every cycle.

Top module: `lfc_link`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls with no traffic, `linkTx` is all zero, `txReady` is zero and `rxValid` is zero.
- R2: Flit bits 34:32 hold the transfer type: 3'b001 is a command head, 3'b010 is single data and 3'b011 is burst data. A command head with bit 31 set opens a 17-flit packet; with bit 31 clear it opens a 2-flit packet. Any other code at a packet boundary is sent as a 1-flit packet.
- R3: Each channel's transmit credit starts at 17. It drops by one per flit sent and rises by one per credit received. A packet starts only when the credit is at least its length. Once started, the packet's remaining flits need no further credit check.
- R4: At most one `txReady` bit is high per cycle, and only for a channel whose `txValid` is high and that passes R3. The choice is round-robin, searching from the channel after the last one granted; the first grant after reset goes to the lowest eligible channel, starting from channel 0.
- R5: Link word bits: 42 is data valid, 41:39 is data channel, 38 is credit valid, 37:35 is credit channel, and 34:0 is the flit. A flit granted in a cycle is in `linkTx` after that cycle's clock edge. A cycle with no grant sends data valid 0, which makes an idle word.
- R6: Each channel has a 17-flit FIFO for received flits. `rxValid` is high while the FIFO is non-empty, and `rxFlit` shows its oldest flit. `rxPop` removes that flit; a pop on an empty FIFO is ignored.
- R7: Each accepted pop owes one credit to the sender. Each outgoing word returns at most one owed credit, chosen round-robin among the channels that are owed one. A pop in cycle k produces its credit in `linkTx` after the edge that ends cycle k+1.
- R8: Between two instances, no flit ever arrives at a full receive buffer.
- R9: Flits on one channel are delivered in the order they were sent, and packets on one channel never interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txValid | input | 8 | Router has a flit on each channel |
| txFlit | input | 280 | One 35-bit flit per channel; channel v occupies bits 35v+34:35v |
| txReady | output | 8 | One-hot grant; the offered flit is taken at this edge |
| linkTx | output | 43 | Registered outgoing link word |
| linkRx | input | 43 | Incoming link word from the peer |
| rxValid | output | 8 | Receive FIFO of the channel is non-empty |
| rxFlit | output | 280 | Oldest received flit per channel |
| rxPop | input | 8 | Router removes the head flit of the channel |

## Verification
A grant seen in cycle k puts the flit on the sender's link in cycle k+1, and the flit is readable from the peer's FIFO in cycle k+2. A pop in cycle k shows up as a credit word on the return link in cycle k+2, and the sender can use that credit from cycle k+3. The bench drives inputs after the falling edge, samples just after that, and records cycle numbers, so every latency is checked against these exact offsets. The credit-limit checks let a stalled channel run for many cycles before counting what went through, so only the steady state is judged.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int NUM_VC    = 8;
  localparam int FLIT_W    = 35;
  localparam int BUF_DEPTH = 17;
  localparam int VC_W      = $clog2(NUM_VC);
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
  localparam int LINK_W    = FLIT_W + 2 * VC_W + 2;
  localparam int BURST_BIT = FLIT_W - 4;

  localparam logic [2:0] TYPE_CMD    = 3'b001;
  localparam logic [2:0] TYPE_SINGLE = 3'b010;
  localparam logic [2:0] TYPE_BURST  = 3'b011;

  typedef struct packed {
    logic            dValid;
    logic [VC_W-1:0] dVc;
    logic            cValid;
    logic [VC_W-1:0] cVc;
    logic [FLIT_W-1:0] flit;
  } link_t;

  typedef struct packed {
    logic            sendValid;
    logic [VC_W-1:0] sendVc;
    logic            retValid;
    logic [VC_W-1:0] retVc;
  } strobe_t;
endpackage

// File: rtl/lfc_rr_arb.sv
module lfc_rr_arb #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic                 anyGrant,
  output logic [$clog2(N)-1:0] grantIdx
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] last;

  always_comb begin
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!anyGrant && req[(int'(last) + k) % N]) begin
        anyGrant = 1'b1;
        grantIdx = IDX_W'((int'(last) + k) % N);
      end
    end
    grant = anyGrant ? (N'(1) << grantIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IDX_W'(N - 1);
    else if (anyGrant) last <= grantIdx;
  end
endmodule

// File: rtl/lfc_ctrl.sv
module lfc_ctrl
  import lfc_pkg::*;
#(
  parameter int NumVc    = NUM_VC,
  parameter int FlitW    = FLIT_W,
  parameter int BufDepth = BUF_DEPTH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NumVc-1:0]       txValid,
  input  logic [NumVc*FlitW-1:0] txFlit,
  input  logic                   crInValid,
  input  logic [VC_W-1:0]        crInVc,
  input  logic [NumVc-1:0]       popAcc,
  output logic [NumVc-1:0]       txReady,
  output strobe_t                strobe
);
  localparam int CntW = $clog2(BufDepth + 1);
  localparam int IdxW = $clog2(NumVc);
  localparam logic [CntW-1:0] LEN_ONE   = CntW'(1);
  localparam logic [CntW-1:0] LEN_SHORT = CntW'(2);
  localparam logic [CntW-1:0] LEN_LONG  = CntW'(BufDepth);

  logic [NumVc-1:0] eligible, owedAny, txGrant, crGrant;
  logic             txAny, crAny;
  logic [IdxW-1:0]  txIdx, crIdx;

  for (genvar v = 0; v < NumVc; v++) begin : g_vc
    logic [CntW-1:0]  credit, remain, owed, headLen;
    logic [FlitW-1:0] front;
    logic             gotCredit;

    assign front     = txFlit[v*FlitW +: FlitW];
    assign headLen   = (front[FlitW-1 -: 3] != TYPE_CMD) ? LEN_ONE :
                       (front[FlitW-4] ? LEN_LONG : LEN_SHORT);
    assign gotCredit = crInValid && (crInVc == VC_W'(v));
    assign eligible[v] = txValid[v] && ((remain != '0) || (credit >= headLen));
    assign owedAny[v]  = (owed != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        credit <= LEN_LONG;
        remain <= '0;
        owed   <= '0;
      end else begin
        credit <= credit - CntW'(txGrant[v]) + CntW'(gotCredit);
        owed   <= owed + CntW'(popAcc[v]) - CntW'(crGrant[v]);
        if (txGrant[v]) remain <= (remain == '0) ? headLen - LEN_ONE : remain - LEN_ONE;
      end
    end
  end

  lfc_rr_arb #(.N(NumVc)) u_txArb (
    .clk(clk), .rst(rst), .req(eligible),
    .grant(txGrant), .anyGrant(txAny), .grantIdx(txIdx)
  );

  lfc_rr_arb #(.N(NumVc)) u_crArb (
    .clk(clk), .rst(rst), .req(owedAny),
    .grant(crGrant), .anyGrant(crAny), .grantIdx(crIdx)
  );

  assign txReady = txGrant;

  always_comb begin
    strobe.sendValid = txAny;
    strobe.sendVc    = VC_W'(txIdx);
    strobe.retValid  = crAny;
    strobe.retVc     = VC_W'(crIdx);
  end
endmodule

// File: rtl/lfc_dp.sv
module lfc_dp
  import lfc_pkg::*;
#(
  parameter int NumVc    = NUM_VC,
  parameter int FlitW    = FLIT_W,
  parameter int BufDepth = BUF_DEPTH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                strobe,
  input  logic [NumVc*FlitW-1:0] txFlit,
  input  logic [LINK_W-1:0]      linkRx,
  input  logic [NumVc-1:0]       rxPop,
  output logic [LINK_W-1:0]      linkTx,
  output logic [NumVc-1:0]       rxValid,
  output logic [NumVc*FlitW-1:0] rxFlit,
  output logic [NumVc-1:0]       bufFull,
  output logic [NumVc-1:0]       popAcc,
  output logic                   crInValid,
  output logic [VC_W-1:0]        crInVc
);
  localparam int CntW = $clog2(BufDepth + 1);
  localparam int PtrW = $clog2(BufDepth);

  link_t txWord, rxWord;

  assign rxWord    = link_t'(linkRx);
  assign linkTx    = txWord;
  assign crInValid = rxWord.cValid;
  assign crInVc    = rxWord.cVc;

  always_ff @(posedge clk) begin
    if (rst) begin
      txWord <= '0;
    end else begin
      txWord.dValid <= strobe.sendValid;
      txWord.dVc    <= strobe.sendVc;
      txWord.cValid <= strobe.retValid;
      txWord.cVc    <= strobe.retValid ? strobe.retVc : '0;
      txWord.flit   <= strobe.sendValid ? txFlit[int'(strobe.sendVc)*FlitW +: FlitW] : '0;
    end
  end

  for (genvar v = 0; v < NumVc; v++) begin : g_buf
    logic [FlitW-1:0] mem [BufDepth];
    logic [PtrW-1:0]  wrPtr, rdPtr;
    logic [CntW-1:0]  fill;
    logic             doPush, doPop;

    assign bufFull[v] = (fill == CntW'(BufDepth));
    assign doPush     = rxWord.dValid && (rxWord.dVc == VC_W'(v)) && !bufFull[v];
    assign doPop      = rxPop[v] && (fill != '0);
    assign popAcc[v]  = doPop;
    assign rxValid[v] = (fill != '0);
    assign rxFlit[v*FlitW +: FlitW] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= rxWord.flit;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fill  <= '0;
      end else begin
        if (doPush) wrPtr <= (wrPtr == PtrW'(BufDepth - 1)) ? '0 : wrPtr + PtrW'(1);
        if (doPop)  rdPtr <= (rdPtr == PtrW'(BufDepth - 1)) ? '0 : rdPtr + PtrW'(1);
        fill <= fill + CntW'(doPush) - CntW'(doPop);
      end
    end
  end
endmodule

// File: rtl/lfc_link.sv
module lfc_link
  import lfc_pkg::*;
#(
  parameter int NumVc    = NUM_VC,
  parameter int FlitW    = FLIT_W,
  parameter int BufDepth = BUF_DEPTH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NumVc-1:0]       txValid,
  input  logic [NumVc*FlitW-1:0] txFlit,
  output logic [NumVc-1:0]       txReady,
  output logic [LINK_W-1:0]      linkTx,
  input  logic [LINK_W-1:0]      linkRx,
  output logic [NumVc-1:0]       rxValid,
  output logic [NumVc*FlitW-1:0] rxFlit,
  input  logic [NumVc-1:0]       rxPop
);
  strobe_t          strobe;
  logic [NumVc-1:0] bufFull, popAcc;
  logic             crInValid;
  logic [VC_W-1:0]  crInVc;

  lfc_ctrl #(.NumVc(NumVc), .FlitW(FlitW), .BufDepth(BufDepth)) u_ctrl (
    .clk(clk), .rst(rst), .txValid(txValid), .txFlit(txFlit),
    .crInValid(crInValid), .crInVc(crInVc), .popAcc(popAcc),
    .txReady(txReady), .strobe(strobe)
  );

  lfc_dp #(.NumVc(NumVc), .FlitW(FlitW), .BufDepth(BufDepth)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .txFlit(txFlit),
    .linkRx(linkRx), .rxPop(rxPop), .linkTx(linkTx),
    .rxValid(rxValid), .rxFlit(rxFlit), .bufFull(bufFull),
    .popAcc(popAcc), .crInValid(crInValid), .crInVc(crInVc)
  );
endmodule

// File: rtl/lfc_link_chk.sv
module lfc_link_chk
  import lfc_pkg::*;
#(
  parameter int NumVc = NUM_VC
) (
  input logic              clk,
  input logic              rst,
  input logic [NumVc-1:0]  txValid,
  input logic [NumVc-1:0]  txReady,
  input logic [LINK_W-1:0] linkTx,
  input logic [LINK_W-1:0] linkRx,
  input logic [NumVc-1:0]  bufFull
);
  link_t lt, lr;
  assign lt = link_t'(linkTx);
  assign lr = link_t'(linkRx);

  // R4
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(txReady));

  // R4
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst) (txReady & ~txValid) == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    lr.dValid |-> !bufFull[lr.dVc]);

  // R5
  send_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (|txReady) |=> (lt.dValid && ((NumVc'(1) << lt.dVc) == $past(txReady))));

  // R5
  idle_word_chk: assert property (@(posedge clk) disable iff (rst)
    !(|txReady) |=> !lt.dValid);
endmodule

bind lfc_link lfc_link_chk #(.NumVc(NumVc)) u_chk (
  .clk(clk), .rst(rst), .txValid(txValid), .txReady(txReady),
  .linkTx(linkTx), .linkRx(linkRx), .bufFull(bufFull)
);

// File: tb/sim_lfc_link.sv
module sim_lfc_link;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int FW = 35;
  localparam int DEPTH = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NV-1:0]    txValid0, txReady0, rxValid0, rxPop0;
  logic [NV*FW-1:0] txFlit0, rxFlit0;
  logic [NV-1:0]    txValid1, txReady1, rxValid1, rxPop1;
  logic [NV*FW-1:0] txFlit1, rxFlit1;
  logic [42:0]      link01, link10;

  lfc_link u0 (.clk(clk), .rst(rst), .txValid(txValid0), .txFlit(txFlit0), .txReady(txReady0),
               .linkTx(link01), .linkRx(link10), .rxValid(rxValid0), .rxFlit(rxFlit0), .rxPop(rxPop0));
  lfc_link u1 (.clk(clk), .rst(rst), .txValid(txValid1), .txFlit(txFlit1), .txReady(txReady1),
               .linkTx(link10), .linkRx(link01), .rxValid(rxValid1), .rxFlit(rxFlit1), .rxPop(rxPop1));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;
  int seqNo = 0;

  logic [FW-1:0] srcQ [NV][$];
  logic [FW-1:0] expQ [NV][$];
  int grantLog[$];
  int sent [NV];
  int credSeen [NV];
  int arrived [NV];
  int popped [NV];
  int u1Data = 0;
  int firstCredCyc = -1;
  int firstRxCyc = -1;
  int overflowSeen = 0;
  logic [NV-1:0] popMask;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [FW-1:0] mkFlit(input logic [2:0] t, input logic b, input int v, input int s);
    return {t, b, 8'(v), 23'(s)};
  endfunction

  // R2 encoding: 001 command head (bit 31 = 17-flit), 010 single, 011 burst
  task automatic pushPkt(input int v, input bit isLong);
    logic [FW-1:0] f;
    f = mkFlit(3'b001, isLong, v, seqNo++);
    srcQ[v].push_back(f); expQ[v].push_back(f);
    if (isLong) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        f = mkFlit(3'b011, 1'b0, v, seqNo++);
        srcQ[v].push_back(f); expQ[v].push_back(f);
      end
    end else begin
      f = mkFlit(3'b010, 1'b0, v, seqNo++);
      srcQ[v].push_back(f); expQ[v].push_back(f);
    end
  endtask

  task automatic cycle();
    logic [NV-1:0] rdy;
    logic [FW-1:0] got;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      txValid0[v] = (srcQ[v].size() != 0);
      txFlit0[v*FW +: FW] = (srcQ[v].size() != 0) ? srcQ[v][0] : '0;
    end
    rxPop1 = popMask;
    #1;
    cyc++;
    rdy = txReady0;
    for (int v = 0; v < NV; v++) begin
      if (rdy[v]) begin sent[v]++; grantLog.push_back(v); end
      if (rxValid1[v] && popMask[v]) begin
        got = rxFlit1[v*FW +: FW];
        popped[v]++;
        if (firstRxCyc < 0) firstRxCyc = cyc;
        if (expQ[v].size() == 0) chk(1'b0, "R9 unexpected flit", longint'(got), 0);
        else begin
          chk(got == expQ[v][0], "R9 order", longint'(got), longint'(expQ[v][0]));
          void'(expQ[v].pop_front());
        end
      end
    end
    if (link10[38]) begin
      credSeen[link10[37:35]]++;
      if (firstCredCyc < 0) firstCredCyc = cyc;
    end
    if (link10[42]) u1Data++;
    if (link01[42]) begin
      arrived[link01[41:39]]++;
      if (arrived[link01[41:39]] - popped[link01[41:39]] > DEPTH) overflowSeen++;
    end
    @(posedge clk);
    for (int v = 0; v < NV; v++) if (rdy[v]) void'(srcQ[v].pop_front());
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  function automatic bit allDrained();
    for (int v = 0; v < NV; v++) if (expQ[v].size() != 0 || srcQ[v].size() != 0) return 0;
    return 1;
  endfunction

  task automatic clearCounts();
    for (int v = 0; v < NV; v++) begin sent[v] = 0; credSeen[v] = 0; end
    grantLog.delete();
  endtask

  initial begin
    txValid0 = '0; txFlit0 = '0; rxPop0 = '1;
    txValid1 = '0; txFlit1 = '0; rxPop1 = '0;
    popMask = '1;
    for (int v = 0; v < NV; v++) begin sent[v] = 0; credSeen[v] = 0; arrived[v] = 0; popped[v] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(link01 == '0, "R1 linkTx in reset", longint'(link01), 0);
    chk(rxValid1 == '0, "R1 rxValid in reset", longint'(rxValid1), 0);
    @(negedge clk) rst = 1'b0;
    run(2);
    // R1 after reset with no traffic
    chk(link01 == '0, "R1 linkTx idle", longint'(link01), 0);
    chk(txReady0 == '0, "R1 txReady idle", longint'(txReady0), 0);
    chk(rxValid1 == '0, "R1 rxValid idle", longint'(rxValid1), 0);

    // R4: round-robin order, one short packet per channel
    clearCounts();
    for (int v = 0; v < NV; v++) pushPkt(v, 1'b0);
    run(40);
    chk(grantLog.size() == 2*NV, "R4 grant count", grantLog.size(), 2*NV);
    for (int i = 0; i < grantLog.size() && i < 2*NV; i++)
      chk(grantLog[i] == i % NV, "R4 round-robin order", grantLog[i], i % NV);
    chk(allDrained(), "R9 all delivered rr", 0, 1);

    // R3 with R2 long packets: second 17-flit packet waits for a full refill
    clearCounts();
    popMask = '1; popMask[2] = 1'b0;
    pushPkt(2, 1'b1); pushPkt(2, 1'b1);
    run(80);
    chk(sent[2] == DEPTH, "R3 long packet gated", sent[2], DEPTH);
    popMask = '1;
    run(150);
    chk(sent[2] == 2*DEPTH, "R3 long packet resumes", sent[2], 2*DEPTH);
    chk(allDrained(), "R9 all delivered long", 0, 1);

    // R3 short packets: 8 fit, a ninth needs 2 credits with 1 left
    clearCounts();
    popMask = '1; popMask[5] = 1'b0;
    for (int i = 0; i < 9; i++) pushPkt(5, 1'b0);
    pushPkt(6, 1'b0);
    run(60);
    chk(sent[5] == 16, "R3 short packet gated", sent[5], 16);
    chk(sent[6] == 2, "R3 other channel unaffected", sent[6], 2);
    popMask = '1;
    run(80);
    chk(sent[5] == 18, "R3 short resumes", sent[5], 18);
    chk(allDrained(), "R9 all delivered short", 0, 1);

    // R5/R6/R7 latency: grant k -> peer rxValid k+2; pop k -> credit word k+2
    clearCounts();
    popMask = '0;
    run(5);
    u1Data = 0;
    firstRxCyc = -1;
    pushPkt(4, 1'b0);
    cycle();
    begin
      int grantCyc;
      grantCyc = cyc;
      chk(sent[4] == 1, "R4 immediate grant", sent[4], 1);
      cycle();
      chk(link01[42] == 1'b1 && link01[41:39] == 3'd4, "R5 link word next cycle",
          longint'(link01[42:39]), longint'(4'b1100));
      cycle();
      chk(rxValid1[4] == 1'b1 && (cyc - grantCyc) == 2, "R6 peer rxValid latency",
          longint'(rxValid1), 16);
    end
    run(4);
    firstCredCyc = -1;
    popMask[4] = 1'b1;
    cycle();
    begin
      int popCyc;
      popCyc = cyc;
      run(6);
      chk(credSeen[4] == 2, "R7 one credit per pop", credSeen[4], 2);
      chk(firstCredCyc - popCyc == 2, "R7 credit latency", firstCredCyc - popCyc, 2);
      chk(u1Data == 0, "R5 credit-only idle words", u1Data, 0);
    end
    chk(rxValid1[4] == 1'b0, "R6 buffer empty after pops", longint'(rxValid1), 0);
    popMask = '1;
    run(4);
    chk(rxValid1 == '0, "R6 pop on empty ignored", longint'(rxValid1), 0);

    // Near-exhaustive sweep: mixed lengths, varying drain patterns
    for (int r = 0; r < 4; r++) begin
      for (int v = 0; v < NV; v++) begin
        pushPkt(v, ((v + r) % 3) == 0);
        pushPkt(v, ((v + r) % 2) == 0);
      end
      for (int i = 0; i < 1500 && !allDrained(); i++) begin
        for (int v = 0; v < NV; v++) popMask[v] = ((cyc + 3*v) % (r + 2)) != 0;
        cycle();
      end
      popMask = '1;
      run(10);
      chk(allDrained(), "R9 sweep delivered", r, 1);
    end
    chk(overflowSeen == 0, "R8 no buffer overflow", overflowSeen, 0);

    // R3 credits fully restored: a 17-flit packet per channel goes through undrained
    clearCounts();
    popMask = '0;
    for (int v = 0; v < NV; v++) pushPkt(v, 1'b1);
    run(200);
    for (int v = 0; v < NV; v++) chk(sent[v] == DEPTH, "R3 credit restored", sent[v], DEPTH);
    popMask = '1;
    run(200);
    chk(allDrained(), "R9 final drain", 0, 1);
    chk(overflowSeen == 0, "R8 no overflow at end", overflowSeen, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule